// File: doc/BRIEF.md
# Per-Core Local Interrupt and Mailbox Unit

This block sits beside a four-core cluster and turns per-core interrupt sources into one IRQ line per core. Each core owns four 32-bit mailboxes. Any agent on the register port can post bits into any mailbox, and the owning core reads and clears them. A nonzero mailbox raises that core's IRQ while its enable bit is set. The block also gates four externally generated timer interrupt levels per core. It has no timer of its own.

All access goes through one word-wide register port. The port takes one write per cycle and one read per cycle, and read data comes back one cycle after the request. The offsets of the control, prescaler, per-core enable, pending and mailbox windows are fixed, because software locates cores and mailboxes by address arithmetic.

Top module: `core_mailbox_intc`

## Requirements
- R1: After reset, every register reads as zero, every mailbox is empty and all IRQ outputs are low.
- R2: The general control word at offset 0x00 and the prescaler word at 0x08 store and read back all 32 bits written, for example 0x80000000.
- R3: The timer-enable register of core n at 0x40 + 4n stores the low 4 bits of a write and reads back with the upper bits zero.
- R4: The mailbox-enable register of core n at 0x50 + 4n stores the low 4 bits of a write and reads back with the upper bits zero.
- R5: A write to the post address 0x80 + 16n + 4m ORs the written value into mailbox m of core n. Reading the post address returns zero.
- R6: Reading the clear address 0xC0 + 16n + 4m returns mailbox m of core n. A write there clears each bit written as one and leaves the other bits unchanged.
- R7: The pending register of core n at 0x60 + 4n is read-only. Bit k (0..3) is timer input k of core n ANDed with timer-enable bit k. Bit 4 + m is "mailbox m of core n is nonzero" ANDed with mailbox-enable bit m. Bits 31:8 read zero, and writes to this register are ignored.
- R8: The IRQ output of core n is the OR of that core's pending bits. It follows register and timer-input changes with no added delay.
- R9: While a core's timer-enable and mailbox-enable registers are both zero, its IRQ stays low whatever its timer inputs and mailboxes hold.
- R10: A post or clear aimed at one mailbox leaves every other mailbox and every other core's IRQ unchanged.
- R11: A read request is answered in the next cycle with the valid flag set. The valid flag is low in any cycle that follows no request. Unmapped word offsets read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| tmr_src | input | 16 | Timer interrupt levels, four per core; core n uses bits 4n+3:4n |
| irq | output | 4 | Interrupt line per core |

## Verification
The bench drives timer inputs all high and then all low while the enables are zero and while they are partly set. This separates the gating of the enables from plain passing of the sources. Mailbox posts use several separate bits, so the OR accumulation of posting is distinguishable from overwriting. Clears that remove one bit, and then the last bit, show that the pending bit tracks "nonzero" rather than a particular bit. Reads of neighbouring mailboxes and cores, and writes to the read-only and unmapped offsets, catch address decoding that hits the wrong core or window.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
    localparam int NCORE  = 4;
    localparam int NBOX   = 4;
    localparam int NTSRC  = 4;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int CW     = $clog2(NCORE);
    localparam int BW     = $clog2(NBOX);
    localparam int PEND_W = NTSRC + NBOX;

    typedef enum logic [2:0] {
        RG_NONE, RG_CTRL, RG_PRESC, RG_TCTL, RG_MCTL, RG_PEND, RG_MSET, RG_MCLR
    } rg_kind_e;

    typedef struct packed {
        rg_kind_e        kind;
        logic [CW-1:0]   core;
        logic [BW-1:0]   box;
    } rg_sel_t;

    typedef struct packed {
        logic [NTSRC-1:0] tmr_en;
        logic [NBOX-1:0]  mb_en;
    } core_cfg_t;

    // Offset map: 0x00 ctrl, 0x08 prescaler, 0x40/0x50/0x60 + 4n per-core
    // windows, 0x80 + 16n + 4m post, 0xC0 + 16n + 4m read/clear.
    function automatic rg_sel_t decode(input logic [AW-1:0] a);
        rg_sel_t s;
        s.kind = RG_NONE;
        s.core = a[3:2];
        s.box  = a[3:2];
        if (a[1:0] == 2'b00) begin
            if (a[7]) begin
                s.kind = a[6] ? RG_MCLR : RG_MSET;
                s.core = a[5:4];
            end else begin
                case (a[6:4])
                    3'd0: begin
                        if (a[3:2] == 2'd0) s.kind = RG_CTRL;
                        else if (a[3:2] == 2'd2) s.kind = RG_PRESC;
                    end
                    3'd4: s.kind = RG_TCTL;
                    3'd5: s.kind = RG_MCTL;
                    3'd6: s.kind = RG_PEND;
                    default: s.kind = RG_NONE;
                endcase
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/cmi_mbox_word.sv
module cmi_mbox_word #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_we,
    input  logic [DW-1:0] set_data,
    input  logic          clr_we,
    input  logic [DW-1:0] clr_data,
    output logic [DW-1:0] word_q
);
    logic [DW-1:0] set_mask, clr_mask;

    assign set_mask = set_we ? set_data : '0;
    assign clr_mask = clr_we ? clr_data : '0;

    // Clear applies first, then set, so a set on the same bit survives.
    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= (word_q & ~clr_mask) | set_mask;
    end

    assert_post_sets_R5: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((word_q & $past(set_data)) == $past(set_data)));

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((word_q & $past(clr_data)) == '0));

    assert_untouched_R10: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(word_q));
endmodule

// File: rtl/cmi_core_pend.sv
module cmi_core_pend
    import cmi_pkg::*;
(
    input  logic [NTSRC-1:0]  tsrc,
    input  core_cfg_t         cfg,
    input  logic [NBOX-1:0]   mb_nz,
    output logic [PEND_W-1:0] pend,
    output logic              irq
);
    assign pend = {mb_nz & cfg.mb_en, tsrc & cfg.tmr_en};
    assign irq  = |pend;
endmodule

// File: rtl/core_mailbox_intc.sv
module core_mailbox_intc
    import cmi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [AW-1:0]          bus_addr,
    input  logic                   bus_wr,
    input  logic [DW-1:0]          bus_wdata,
    input  logic                   bus_rd,
    output logic [DW-1:0]          bus_rdata,
    output logic                   bus_rvalid,
    input  logic [NCORE*NTSRC-1:0] tmr_src,
    output logic [NCORE-1:0]       irq
);
    rg_sel_t sel;
    assign sel = decode(bus_addr);

    logic [DW-1:0] ctrl_q, presc_q;
    core_cfg_t     cfg_q [NCORE];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            for (int c = 0; c < NCORE; c++) cfg_q[c] <= '0;
        end else if (bus_wr) begin
            case (sel.kind)
                RG_CTRL:  ctrl_q  <= bus_wdata;
                RG_PRESC: presc_q <= bus_wdata;
                RG_TCTL:  cfg_q[sel.core].tmr_en <= bus_wdata[NTSRC-1:0];
                RG_MCTL:  cfg_q[sel.core].mb_en  <= bus_wdata[NBOX-1:0];
                default: ;
            endcase
        end
    end

    logic [NCORE-1:0][NBOX-1:0][DW-1:0] mbox_q;
    logic [NCORE-1:0][PEND_W-1:0]       pend;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [NBOX-1:0] nz;
        for (genvar m = 0; m < NBOX; m++) begin : g_box
            logic hit;
            assign hit = bus_wr && (sel.core == CW'(c)) && (sel.box == BW'(m));
            cmi_mbox_word #(.DW(DW)) u_word (
                .clk      (clk),
                .rst      (rst),
                .set_we   (hit && sel.kind == RG_MSET),
                .set_data (bus_wdata),
                .clr_we   (hit && sel.kind == RG_MCLR),
                .clr_data (bus_wdata),
                .word_q   (mbox_q[c][m])
            );
            assign nz[m] = |mbox_q[c][m];
        end

        cmi_core_pend u_pend (
            .tsrc  (tmr_src[c*NTSRC +: NTSRC]),
            .cfg   (cfg_q[c]),
            .mb_nz (nz),
            .pend  (pend[c]),
            .irq   (irq[c])
        );

        assert_quiet_core_R9: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[c].tmr_en == '0 && cfg_q[c].mb_en == '0) |-> !irq[c]);
    end

    logic [DW-1:0] rd_mux;
    always_comb begin
        case (sel.kind)
            RG_CTRL:  rd_mux = ctrl_q;
            RG_PRESC: rd_mux = presc_q;
            RG_TCTL:  rd_mux = DW'(cfg_q[sel.core].tmr_en);
            RG_MCTL:  rd_mux = DW'(cfg_q[sel.core].mb_en);
            RG_PEND:  rd_mux = DW'(pend[sel.core]);
            RG_MCLR:  rd_mux = mbox_q[sel.core][sel.box];
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : '0;
        end
    end

    assert_read_answered_R11: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    assert_pend_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel.kind == RG_PEND) |=> (bus_rdata[DW-1:PEND_W] == '0));
endmodule

// File: tb/core_mailbox_intc_bench.sv
`timescale 1ns/1ps
module core_mailbox_intc_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] tmr_src = '0;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    core_mailbox_intc u_core_mailbox_intc (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .tmr_src(tmr_src), .irq(irq)
    );

    // Monitor: pop one expectation for each answered read.
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11: read data %h with no request outstanding", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic [3:0] e, input string t);
        #1;
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk_irq(4'b0000, "R1");
        checks++;
        if (bus_rvalid !== 1'b0) begin
            errors++; $display("FAIL R11: rvalid got %b expected 0", bus_rvalid);
        end
        rd(8'h00, 32'h0, "R1");
        rd(8'h08, 32'h0, "R1");
        rd(8'h60, 32'h0, "R1");
        rd(8'hC0, 32'h0, "R1");

        // R2: control and prescaler words
        wr(8'h00, 32'h1234_5678);
        wr(8'h08, 32'h8000_0000);
        rd(8'h00, 32'h1234_5678, "R2");
        rd(8'h08, 32'h8000_0000, "R2");

        // R9: sources high, every enable zero
        tmr_src = 16'hFFFF;
        chk_irq(4'b0000, "R9");

        // R3, R7, R8: core 1 timer enables 0 and 2
        wr(8'h44, 32'hFFFF_FFF5);
        rd(8'h44, 32'h5, "R3");
        rd(8'h64, 32'h05, "R7");
        chk_irq(4'b0010, "R8");
        tmr_src = 16'h0000;
        chk_irq(4'b0000, "R7");

        // R5: posts accumulate; enables still zero for core 2
        wr(8'hA4, 32'h0000_0008);
        wr(8'hA4, 32'h0002_0000);
        rd(8'hE4, 32'h0002_0008, "R5");
        rd(8'hA4, 32'h0, "R5");
        rd(8'h68, 32'h0, "R7");
        chk_irq(4'b0000, "R9");

        // R4: mailbox enable for core 2 box 1
        wr(8'h58, 32'hFFFF_FFF2);
        rd(8'h58, 32'h2, "R4");
        rd(8'h68, 32'h20, "R7");
        chk_irq(4'b0100, "R8");

        // R10: neighbours untouched
        rd(8'hC4, 32'h0, "R10");
        rd(8'hF4, 32'h0, "R10");
        rd(8'hE0, 32'h0, "R10");
        rd(8'h6C, 32'h0, "R10");

        // R6: clear one bit, then the last one
        wr(8'hE4, 32'h0000_0008);
        rd(8'hE4, 32'h0002_0000, "R6");
        chk_irq(4'b0100, "R6");
        wr(8'hE4, 32'h0002_0000);
        rd(8'hE4, 32'h0, "R6");
        rd(8'h68, 32'h0, "R6");
        chk_irq(4'b0000, "R6");

        // R11 and R7: unmapped offsets and read-only pending
        rd(8'h04, 32'h0, "R11");
        rd(8'h3C, 32'h0, "R11");
        wr(8'h0C, 32'hDEAD_BEEF);
        wr(8'h68, 32'hFFFF_FFFF);
        rd(8'h00, 32'h1234_5678, "R11");
        rd(8'h68, 32'h0, "R7");

        // R8: two cores at once, timer on core 0, mailbox on core 3
        wr(8'h40, 32'h1);
        wr(8'h5C, 32'h8);
        wr(8'hBC, 32'h1);
        tmr_src = 16'h0001;
        chk_irq(4'b1001, "R8");
        rd(8'h60, 32'h01, "R7");
        rd(8'h6C, 32'h80, "R7");
        rd(8'hFC, 32'h1, "R5");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11: %0d reads unanswered, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule